// File: doc/BRIEF.md
# Four-Block 257-Bit Transcoder

This block merges four consecutive 66-bit line blocks into one 257-bit transcoded word. Each input block carries a 2-bit sync header in its low bits and a 64-bit payload above it. The four sync headers are dropped. They are replaced by one leading flag bit and, when needed, a 4-bit block-kind map. The transcoded word is issued on a one-cycle valid strobe once the fourth block of a group has been accepted.

A matching decoder can be included through a parameter. It takes each transcoded word and rebuilds the four 66-bit blocks, sync headers included. A control block gives up the low nibble of its payload to make room for the map. The decoder writes a fixed, parameter-set nibble back in its place. Payloads are therefore recovered exactly when that nibble of the first control block holds the fixed value.

Top module: `xcode257_top`

## Requirements
- R1: `out_vld` is high for exactly one cycle, in the cycle after the fourth accepted block of a group (a block is accepted when `in_vld` is high at a clock edge). Cycles with `in_vld` low do not count toward the group.
- R2: When all four headers are data, `out_word[0]` is 1, and block i's payload occupies `out_word[64*i+64 : 64*i+1]`.
- R3: When any block is control, `out_word[0]` is 0, and `out_word[i+1]` is 1 if block i (arrival order 0..3) is data and 0 if it is control.
- R4: In the control case, the fields are packed upward from bit 5 in arrival order. The lowest-numbered control block contributes only payload bits [63:4] (60 bits). Every other block contributes its full 64-bit payload.
- R5: A block's header is `in_blk[1:0]` and its payload is `in_blk[65:2]`. Header 2'b01 means data and 2'b10 means control.
- R6: If any header in a group is 2'b00 or 2'b11, `hdr_err` is high together with `out_vld`. The group is then encoded as all-control: `out_word[4:0]` is zero and block 0 loses its nibble.
- R7: `hdr_err` is low on every `out_vld` cycle of a group whose four headers are all legal.
- R8: With the decoder enabled, `dec_vld` rises one cycle after `out_vld`. `dec_blocks[66*i+65 : 66*i]` then holds block i, with header 2'b01 or 2'b10 taken from the flag and map. The first control block's payload bits [3:0] equal `CTRL_NIB`.
- R9: A synchronous reset clears `out_vld`, `dec_vld` and `hdr_err` and discards any partly gathered group, so the next group starts with the next accepted block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input block valid |
| in_blk | input | 66 | Input block: payload [65:2], sync header [1:0] |
| out_vld | output | 1 | Transcoded word valid, one-cycle strobe |
| out_word | output | 257 | Transcoded word |
| hdr_err | output | 1 | Illegal sync header seen in the group just issued |
| dec_vld | output | 1 | Decoded group valid |
| dec_blocks | output | 264 | Four rebuilt 66-bit blocks, block i at [66*i+65:66*i] |

## Verification
The transcoded word and `hdr_err` are registered once. Both become visible in the cycle after the edge that accepts the fourth block. The decoded group passes through one more register and appears a cycle later. The bench drives every block on a falling edge. It samples at the falling edge right after the fourth accepting rising edge to check the encoder side, and at the next falling edge to check the decoder and that `out_vld` has dropped. Idle gaps between blocks check that only accepted blocks advance the group. The sweep covers all sixteen data/control patterns, illegal headers, and a reset in the middle of a group.

// File: rtl/xc_pkg.sv
package xc_pkg;
    localparam int PAY_W  = 64;
    localparam int HDR_W  = 2;
    localparam int BLK_W  = PAY_W + HDR_W;
    localparam int GRP    = 4;
    localparam int NIB_W  = 4;
    localparam int MAP_W  = GRP;
    localparam int OUT_W  = GRP * PAY_W + 1;
    localparam int CUT_W  = PAY_W - NIB_W;
    localparam int CNT_W  = $clog2(GRP);

    localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;
    localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

    typedef struct packed {
        logic [PAY_W-1:0] pay;
        logic [HDR_W-1:0] hdr;
    } blk_t;

    typedef blk_t [GRP-1:0] grp_t;

    function automatic logic hdr_is_data(input blk_t b);
        return b.hdr == HDR_DATA;
    endfunction

    function automatic logic hdr_legal(input blk_t b);
        return (b.hdr == HDR_DATA) || (b.hdr == HDR_CTRL);
    endfunction
endpackage

// File: rtl/xc_gather.sv
module xc_gather
    import xc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_vld,
    input  blk_t in_blk,
    output grp_t grp,
    output logic grp_done
);
    logic [CNT_W-1:0] cnt;
    blk_t             slots [GRP-1];

    assign grp_done = in_vld && (cnt == CNT_W'(GRP - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (in_vld) begin
            cnt <= (cnt == CNT_W'(GRP - 1)) ? '0 : cnt + 1'b1;
        end
    end

    for (genvar s = 0; s < GRP - 1; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (in_vld && cnt == CNT_W'(s))
                slots[s] <= in_blk;
        end
        assign grp[s] = slots[s];
    end
    assign grp[GRP-1] = in_blk;

    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !grp_done) |=> (cnt == $past(cnt) + 1'b1)) else $error("gather count"); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(cnt)) else $error("idle moved count"); // R1
endmodule

// File: rtl/xc_pack.sv
module xc_pack
    import xc_pkg::*;
(
    input  grp_t             grp,
    output logic [OUT_W-1:0] word,
    output logic             bad_hdr
);
    logic [MAP_W-1:0] kind;
    int               pos;
    logic             cut_done;

    always_comb begin
        bad_hdr = 1'b0;
        for (int i = 0; i < GRP; i++) begin
            kind[i] = hdr_is_data(grp[i]);
            if (!hdr_legal(grp[i])) bad_hdr = 1'b1;
        end
        if (bad_hdr) kind = '0;

        word     = '0;
        pos      = 1 + MAP_W;
        cut_done = 1'b0;
        if (&kind) begin
            word[0] = 1'b1;
            for (int i = 0; i < GRP; i++)
                word[1 + i*PAY_W +: PAY_W] = grp[i].pay;
        end else begin
            word[MAP_W:1] = kind;
            for (int i = 0; i < GRP; i++) begin
                if (!kind[i] && !cut_done) begin
                    word[pos +: CUT_W] = grp[i].pay[PAY_W-1:NIB_W];
                    pos      = pos + CUT_W;
                    cut_done = 1'b1;
                end else begin
                    word[pos +: PAY_W] = grp[i].pay;
                    pos = pos + PAY_W;
                end
            end
        end
    end
endmodule

// File: rtl/xc_unpack.sv
module xc_unpack
    import xc_pkg::*;
#(
    parameter logic [3:0] CTRL_NIB = 4'hE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [OUT_W-1:0] in_word,
    output logic             dec_vld,
    output grp_t             dec_grp
);
    grp_t             nxt;
    logic [MAP_W-1:0] kind;
    int               pos;
    logic             cut_done;

    always_comb begin
        kind     = in_word[0] ? '1 : in_word[MAP_W:1];
        pos      = in_word[0] ? 1 : 1 + MAP_W;
        cut_done = 1'b0;
        for (int i = 0; i < GRP; i++) begin
            nxt[i].hdr = kind[i] ? HDR_DATA : HDR_CTRL;
            if (!kind[i] && !cut_done) begin
                nxt[i].pay = {in_word[pos +: CUT_W], CTRL_NIB};
                pos        = pos + CUT_W;
                cut_done   = 1'b1;
            end else begin
                nxt[i].pay = in_word[pos +: PAY_W];
                pos        = pos + PAY_W;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_vld <= 1'b0;
        end else begin
            dec_vld <= in_vld;
        end
        if (in_vld) dec_grp <= nxt;
    end

    AST_DEC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> dec_vld) else $error("decode late"); // R8
    AST_DEC_ONLY_AFTER: assert property (@(posedge clk) disable iff (rst)
        dec_vld |-> $past(in_vld)) else $error("spurious decode"); // R8
endmodule

// File: rtl/xcode257_top.sv
module xcode257_top
    import xc_pkg::*;
#(
    parameter bit         HAS_DEC  = 1'b1,
    parameter logic [3:0] CTRL_NIB = 4'hE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic [BLK_W-1:0]     in_blk,
    output logic                 out_vld,
    output logic [OUT_W-1:0]     out_word,
    output logic                 hdr_err,
    output logic                 dec_vld,
    output logic [GRP*BLK_W-1:0] dec_blocks
);
    grp_t             grp;
    logic             grp_done;
    logic [OUT_W-1:0] packed_w;
    logic             bad_hdr;

    xc_gather u_gather (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .in_blk   (blk_t'(in_blk)),
        .grp      (grp),
        .grp_done (grp_done)
    );

    xc_pack u_pack (
        .grp     (grp),
        .word    (packed_w),
        .bad_hdr (bad_hdr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            hdr_err <= 1'b0;
        end else begin
            out_vld <= grp_done;
            hdr_err <= grp_done && bad_hdr;
        end
        if (grp_done) out_word <= packed_w;
    end

    if (HAS_DEC) begin : g_dec
        grp_t dgrp;
        xc_unpack #(.CTRL_NIB(CTRL_NIB)) u_unpack (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (out_vld),
            .in_word (out_word),
            .dec_vld (dec_vld),
            .dec_grp (dgrp)
        );
        assign dec_blocks = dgrp;
    end else begin : g_nodec
        assign dec_vld    = 1'b0;
        assign dec_blocks = '0;
    end

    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_vld |=> !out_vld) else $error("out_vld held"); // R1
    AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(in_vld)) else $error("out without input"); // R1
    AST_ALLDATA_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_word[0]) |-> !hdr_err) else $error("flag with error"); // R7
    AST_ERR_FORMAT: assert property (@(posedge clk) disable iff (rst)
        (out_vld && hdr_err) |-> (out_word[MAP_W:0] == '0)) else $error("error map"); // R6
    AST_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        hdr_err |-> out_vld) else $error("stray error"); // R6
endmodule

// File: tb/xcode257_top_tb.sv
module xcode257_top_tb;
    localparam logic [3:0] NIB = 4'hE;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_vld;
    logic [65:0]  in_blk;
    logic         out_vld;
    logic [256:0] out_word;
    logic         hdr_err;
    logic         dec_vld;
    logic [263:0] dec_blocks;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [65:0] blks [4];

    always #2.5 clk = ~clk;

    xcode257_top #(.HAS_DEC(1'b1), .CTRL_NIB(NIB)) u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_blk(in_blk),
        .out_vld(out_vld), .out_word(out_word), .hdr_err(hdr_err),
        .dec_vld(dec_vld), .dec_blocks(dec_blocks)
    );

    task automatic chk(input bit ok, input string req, input string what);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    task automatic push(input logic [65:0] b, input int gap);
        in_vld = 1'b1;
        in_blk = b;
        @(negedge clk);
        in_vld = 1'b0;
        in_blk = '0;
        for (int k = 0; k < gap; k++) @(negedge clk);
    endtask

    function automatic logic [63:0] mkpay(input int g, input int i);
        logic [31:0] a;
        a = 32'(g * 40503 + i * 2654435 + 17);
        return {a ^ 32'h5A3C_96E1, ~a + 32'(i)};
    endfunction

    function automatic logic [3:0] kind_of(output bit bad);
        logic [3:0] m;
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            if (blks[i][1:0] != 2'b01 && blks[i][1:0] != 2'b10) bad = 1;
            m[i] = (blks[i][1:0] == 2'b01);
        end
        return bad ? 4'h0 : m;
    endfunction

    function automatic logic [256:0] exp_word();
        bit bad;
        logic [3:0] m;
        logic [256:0] r;
        int off;
        bit first;
        m = kind_of(bad);
        if (m == 4'hF) begin
            r = 257'd1;
            for (int i = 0; i < 4; i++) r |= 257'(blks[i][65:2]) << (1 + 64 * i);
        end else begin
            r = 257'(m) << 1;
            off = 5;
            first = 1;
            for (int i = 0; i < 4; i++) begin
                if (!m[i] && first) begin
                    r |= 257'(blks[i][65:6]) << off;
                    off += 60;
                    first = 0;
                end else begin
                    r |= 257'(blks[i][65:2]) << off;
                    off += 64;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [263:0] exp_dec();
        bit bad;
        logic [3:0] m;
        logic [263:0] r;
        logic [63:0] p;
        bit first;
        m = kind_of(bad);
        first = 1;
        for (int i = 0; i < 4; i++) begin
            p = blks[i][65:2];
            if (!m[i] && first) begin
                p[3:0] = NIB;
                first = 0;
            end
            r[66*i +: 66] = {p, m[i] ? 2'b01 : 2'b10};
        end
        return r;
    endfunction

    // hdr_sel: per block 0=data,1=control,2=header 00,3=header 11
    task automatic run_group(input int g, input int sel[4], input int gap, input string tag);
        logic [256:0] ew;
        logic [263:0] ed;
        bit bad;
        logic [3:0] m;
        for (int i = 0; i < 4; i++) begin
            logic [63:0] p;
            logic [1:0] h;
            p = mkpay(g, i);
            case (sel[i])
                0: h = 2'b01;
                1: h = 2'b10;
                2: h = 2'b00;
                default: h = 2'b11;
            endcase
            if (sel[i] != 0 && (g % 2 == 0)) p[3:0] = NIB;
            blks[i] = {p, h};
        end
        ew = exp_word();
        ed = exp_dec();
        m  = kind_of(bad);
        for (int i = 0; i < 3; i++) push(blks[i], gap);
        chk(out_vld === 1'b0, "R1", $sformatf("%s early out_vld=%b exp 0", tag, out_vld));
        push(blks[3], 0);
        chk(out_vld === 1'b1, "R1", $sformatf("%s out_vld=%b exp 1", tag, out_vld));
        chk(out_word === ew, (m == 4'hF) ? "R2" : "R4",
            $sformatf("%s word=%h exp %h", tag, out_word, ew));
        chk(out_word[4:0] === ((m == 4'hF) ? ew[4:0] : {m, 1'b0}), bad ? "R6" : "R3",
            $sformatf("%s head=%b exp map %b", tag, out_word[4:0], m));
        chk(hdr_err === bad, bad ? "R6" : "R7", $sformatf("%s hdr_err=%b exp %b", tag, hdr_err, bad));
        @(negedge clk);
        chk(out_vld === 1'b0, "R1", $sformatf("%s out_vld held=%b exp 0", tag, out_vld));
        chk(dec_vld === 1'b1, "R8", $sformatf("%s dec_vld=%b exp 1", tag, dec_vld));
        chk(dec_blocks === ed, "R8", $sformatf("%s dec=%h exp %h", tag, dec_blocks, ed));
        @(negedge clk);
        chk(dec_vld === 1'b0, "R8", $sformatf("%s dec_vld held=%b exp 0", tag, dec_vld));
    endtask

    initial begin
        int sel[4];
        rst = 1'b1;
        in_vld = 1'b0;
        in_blk = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(out_vld === 1'b0 && dec_vld === 1'b0 && hdr_err === 1'b0, "R9",
            $sformatf("reset outs %b%b%b exp 000", out_vld, dec_vld, hdr_err));

        // R2 R3 R4 R5: every data/control pattern, idle gaps vary
        for (int pat = 0; pat < 16; pat++) begin
            for (int i = 0; i < 4; i++) sel[i] = pat[i] ? 0 : 1;
            run_group(pat, sel, pat % 3, $sformatf("pat%0d", pat));
        end
        // R6: illegal headers
        sel = '{0, 0, 2, 0}; run_group(20, sel, 1, "err00");
        sel = '{3, 1, 0, 0}; run_group(21, sel, 0, "err11");
        sel = '{1, 0, 0, 3}; run_group(22, sel, 2, "errlast");

        // R9: reset discards a partial group
        push({mkpay(30, 0), 2'b01}, 0);
        push({mkpay(30, 1), 2'b10}, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(out_vld === 1'b0, "R9", $sformatf("after reset out_vld=%b exp 0", out_vld));
        sel = '{1, 0, 1, 0}; run_group(31, sel, 0, "postrst");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #500us;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule